// File: doc/BRIEF.md
# External Memory Select and I/O Wait-State Generator

This block drives the external memory-select strobes of a 16-bit processor bus. On each access request it asserts exactly one of four active-low selects (program, data, boot or I/O space) and drives the external address. It signals ready in the access's final cycle.

Accesses to program, data and boot space always take a single cycle. An I/O-space access uses an 11-bit address. The space is split into four equal regions, and each region has its own 3-bit wait register. The block holds the I/O select low for that region's programmed number of extra cycles before it raises ready.

A composite select merges any chosen subset of the four individual selects under a 4-bit mask, so that one memory device can answer in more than one space. It follows the exact timing of the selects it merges.

Top module: `xsel_gen`

## Requirements
- R1: While reset is held and after it is released with no request, all five selects are high, ready is low and the external address is zero.
- R2: Space codes are 0 = program, 1 = data, 2 = boot, 3 = I/O. A request accepted at a clock edge makes the matching select go low in the following cycle. For program, data and boot, the select stays low for exactly one cycle, and ready is high in that cycle.
- R3: For I/O accesses, address bits 10:9 choose the region k, and the wait count is taken from `io_wait[3k+2:3k]`. Region 0 is 0x000–0x1FF, region 1 is 0x200–0x3FF, region 2 is 0x400–0x5FF and region 3 is 0x600–0x7FF.
- R4: An I/O access with wait count W holds `io_sel_n` low for W+1 cycles, where W is 0 to 7. Ready is high only in the last of those cycles.
- R5: At most one individual select is low in any cycle.
- R6: In the cycle after ready, every select is high. A new request is accepted only while the block is idle.
- R7: During a program, data or boot access, the external address equals the 14-bit request address. During an I/O access it equals the low 11 address bits with the top three bits zero. The address holds steady for the whole access and is zero when idle.
- R8: Mask bit 0 selects program, bit 1 data, bit 2 boot and bit 3 I/O. The composite select is low exactly when some individual select whose mask bit is set is low.
- R9: With the mask at zero, the composite select stays high through every kind of access.
- R10: A request raised during an access is ignored. The wait count is sampled when the access starts, so changing the wait registers mid-access leaves its length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while idle |
| space | input | 2 | Target space code |
| addr | input | 14 | Request address |
| io_wait | input | 12 | Four 3-bit region wait counts, region k at bits 3k+2:3k |
| comp_mask | input | 4 | Composite select merge mask |
| pm_sel_n | output | 1 | Program-space select, active low |
| dm_sel_n | output | 1 | Data-space select, active low |
| bm_sel_n | output | 1 | Boot-space select, active low |
| io_sel_n | output | 1 | I/O-space select, active low |
| comp_sel_n | output | 1 | Composite select, active low |
| ext_addr | output | 14 | External address |
| ready | output | 1 | High in the last cycle of an access |

## Verification
The assertions take for granted that the composite mask is steady while an access is in flight. They also assume that requests are single-cycle events relative to the idle state. Neither the wait registers nor the request need to be stable during an access.

The stimulus follows these assumptions. It changes the mask only between accesses, and it deliberately raises stray requests and rewrites the wait registers in the middle of long I/O accesses. Every access is checked cycle by cycle against a computed queue of expected strobe, address and ready values.

// File: rtl/xsel_gen.sv
module xsel_gen #(
  parameter int AW   = 14,
  parameter int IOW  = 11,
  parameter int WW   = 3,
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [1:0]         space,
  input  logic [AW-1:0]      addr,
  input  logic [WW*NREG-1:0] io_wait,
  input  logic [3:0]         comp_mask,
  output logic               pm_sel_n,
  output logic               dm_sel_n,
  output logic               bm_sel_n,
  output logic               io_sel_n,
  output logic               comp_sel_n,
  output logic [AW-1:0]      ext_addr,
  output logic               ready
);
  localparam int RB = $clog2(NREG);
  localparam logic [1:0] SP_IO = 2'd3;

  logic          active;
  logic [1:0]    sp_q;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] cnt;
  logic [3:0]    sel_vec;

  wire [RB-1:0] region = addr[IOW-1 -: RB];
  wire [WW-1:0] wsel   = io_wait[region*WW +: WW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sp_q   <= '0;
      addr_q <= '0;
      cnt    <= '0;
    end else if (!active) begin
      if (req) begin
        active <= 1'b1;
        sp_q   <= space;
        addr_q <= (space == SP_IO) ? AW'(addr[IOW-1:0]) : addr;
        cnt    <= (space == SP_IO) ? wsel : '0;
      end
    end else if (cnt == '0) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign sel_vec    = active ? (4'b0001 << sp_q) : 4'b0000;
  assign {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n} = ~sel_vec;
  assign comp_sel_n = ~|(sel_vec & comp_mask);
  assign ready      = active && (cnt == '0);
  assign ext_addr   = active ? addr_q : '0;

  wire [3:0] sels_n = {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n};

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sels_n));
  a_r4_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sels_n != 4'b1111));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (sels_n == 4'b1111));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && sels_n != 4'b1111) |=> ($stable(sels_n) && $stable(ext_addr)));
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_sel_n || !dm_sel_n || !bm_sel_n) |-> ready);
  a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mask == 4'b0000) |-> comp_sel_n);
  a_r7_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel_n |-> (ext_addr[AW-1:IOW] == '0));
endmodule

// File: tb/xsel_gen_tb.sv
module xsel_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] space = 2'd0;
  logic [13:0] addr = '0;
  logic [11:0] io_wait = '0;
  logic [3:0] comp_mask = '0;
  logic pm_sel_n, dm_sel_n, bm_sel_n, io_sel_n, comp_sel_n, ready;
  logic [13:0] ext_addr;

  always #2.5 clk = ~clk;

  xsel_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .space(space), .addr(addr),
    .io_wait(io_wait), .comp_mask(comp_mask), .pm_sel_n(pm_sel_n),
    .dm_sel_n(dm_sel_n), .bm_sel_n(bm_sel_n), .io_sel_n(io_sel_n),
    .comp_sel_n(comp_sel_n), .ext_addr(ext_addr), .ready(ready)
  );

  typedef struct {
    logic [3:0]  sels_n;
    logic        comp_n;
    logic        rdy;
    logic [13:0] ea;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  task automatic check_item(item_t e);
    logic [3:0] s;
    s = {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n};
    checks++;
    if (s !== e.sels_n || comp_sel_n !== e.comp_n || ready !== e.rdy || ext_addr !== e.ea) begin
      errors++;
      $display("FAIL %s: sels=%b comp=%b rdy=%b ea=%h expected sels=%b comp=%b rdy=%b ea=%h",
               e.tag, s, comp_sel_n, ready, ext_addr, e.sels_n, e.comp_n, e.rdy, e.ea);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && q.size() > 0) check_item(q.pop_front());
  end

  task automatic access(input logic [1:0] sp, input logic [13:0] a,
                        input logic [11:0] wcfg, input logic [3:0] mask,
                        input string tag, input bit poke);
    int w;
    logic [3:0] sv;
    logic [13:0] ea;
    item_t it;
    @(negedge clk);
    io_wait = wcfg; comp_mask = mask;
    space = sp; addr = a; req = 1'b1;
    w  = (sp == 2'd3) ? int'(wcfg[a[10:9]*3 +: 3]) : 0;
    sv = ~(4'b0001 << sp);
    ea = (sp == 2'd3) ? {3'b000, a[10:0]} : a;
    @(posedge clk); #1;
    req = 1'b0;
    for (int c = 0; c <= w; c++) begin
      it.sels_n = sv;
      it.comp_n = ~|(~sv & mask);
      it.rdy    = (c == w);
      it.ea     = ea;
      it.tag    = tag;
      q.push_back(it);
    end
    it.sels_n = 4'b1111; it.comp_n = 1'b1; it.rdy = 1'b0; it.ea = '0;
    it.tag = {tag, " R6 idle after ready"};
    q.push_back(it);
    if (poke) begin
      @(negedge clk);
      req = 1'b1; space = 2'd0; addr = 14'h3ABC; io_wait = 12'h000;
      @(negedge clk);
      req = 1'b0;
    end
    wait (q.size() == 0);
  endtask

  task automatic run_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n, comp_sel_n, ready} !== 6'b111110 || ext_addr !== 14'h0) begin
      errors++;
      $display("FAIL R1 in reset: sels=%b comp=%b rdy=%b ea=%h expected 1111 1 0 0000",
               {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n}, comp_sel_n, ready, ext_addr);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n, comp_sel_n, ready} !== 6'b111110 || ext_addr !== 14'h0) begin
      errors++;
      $display("FAIL R1 idle after reset: sels=%b comp=%b rdy=%b ea=%h expected 1111 1 0 0000",
               {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n}, comp_sel_n, ready, ext_addr);
    end
    access(2'd0, 14'h1234, 12'hFFF, 4'b0001, "R2 R7 R8 program", 1'b0);
    access(2'd1, 14'h3FDF, 12'hFFF, 4'b0011, "R2 R7 R8 data", 1'b0);
    access(2'd2, 14'h2001, 12'hFFF, 4'b0010, "R2 R8 boot unmasked", 1'b0);
    access(2'd3, 14'h3FFF, 12'hFFF, 4'b1000, "R4 R7 io upper bits", 1'b0);
    access(2'd3, 14'h0005, 12'b111_110_101_011, 4'b1000, "R3 region0", 1'b0);
    access(2'd3, 14'h0200, 12'b111_110_101_011, 4'b1000, "R3 region1", 1'b0);
    access(2'd3, 14'h05FF, 12'b111_110_101_011, 4'b1000, "R3 region2", 1'b0);
    access(2'd3, 14'h0600, 12'b111_110_101_011, 4'b1000, "R3 region3", 1'b0);
    access(2'd3, 14'h01FF, 12'b000_000_000_000, 4'b1000, "R4 zero wait", 1'b0);
    access(2'd3, 14'h07FF, 12'b111_000_000_000, 4'b1111, "R4 R8 max wait", 1'b0);
    access(2'd0, 14'h0000, 12'h000, 4'b0000, "R9 program mask zero", 1'b0);
    access(2'd3, 14'h0400, 12'b000_101_000_000, 4'b0000, "R9 io mask zero", 1'b0);
    access(2'd3, 14'h0222, 12'b000_000_101_000, 4'b1000, "R10 busy ignore", 1'b1);
    access(2'd1, 14'h0ABC, 12'h000, 4'b1110, "R5 R8 data merged", 1'b0);
    access(2'd2, 14'h1FFF, 12'h000, 4'b0100, "R2 R6 boot", 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule